// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a small processor core in which each instruction completes in one clock: it is fetched from a local instruction memory, decoded, executed, and its result committed before the next edge. It handles register-register arithmetic and logic, word loads and stores, an equality branch, a jump through a register, a load-upper-immediate, and a store that also advances its base register by four. Both memories are word arrays inside the core. They are filled through a load port while reset is held. A read-only peek port exposes one register and one data word so that results can be observed.

Instruction fields follow the usual 32-bit layout: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], and a 16-bit immediate [15:0]. Memory addresses are byte addresses. Bits 31:2 select the word. An access whose word index falls outside the memory depth reads as zero and does not write. Register 0 always reads as zero.

Top module: `sc_cpu`

## Requirements
- R1: While rst is sampled high at a clock edge, the PC becomes 0 and all registers become 0. Execution starts at address 0 on the first edge with rst low.
- R2: Opcode 0x00 writes rd with rs op rt. The operation is chosen by funct: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0).
- R3: Opcode 0x23 writes rt with the data word at rs plus the sign-extended immediate.
- R4: Opcode 0x2B writes rt into the data word at rs plus the sign-extended immediate. It writes no register.
- R5: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2; otherwise it is PC+4.
- R6: Opcode 0x00 with funct 0x08 loads the PC from rs. It writes no register and no memory.
- R7: Opcode 0x0F writes rt with the immediate in bits 31:16 and zeros below. It writes no memory.
- R8: Opcode 0x3B stores rt to the data word at the original rs plus the sign-extended immediate. In the same cycle it writes rs+4 into rs.
- R9: Register 0 reads as zero and keeps that value whatever is written to it.
- R10: Every instruction other than a taken branch or a register jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_we | input | 1 | Write ld_data into instruction word ld_addr |
| ld_dmem_we | input | 1 | Write ld_data into data word ld_addr |
| ld_addr | input | AW | Word index for the load port |
| ld_data | input | 32 | Load port data |
| pc_out | output | 32 | Current program counter |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Value of register peek_reg |
| peek_addr | input | AW | Data memory word index to observe |
| peek_mem_data | output | 32 | Value of data word peek_addr |

## Verification
The PC and write-enable assertions assume that the instruction words come only from the defined opcodes and funct codes. They also assume that the load port is driven only while rst is high, so that no load-port write competes with a store. The bench holds reset for the whole of each memory load. Every unused instruction slot is filled with a self-branch, so a program parks at a known address. All data addresses the programs compute stay inside the memory depth.

// File: rtl/sc_cpu.sv
module sc_cpu #(
  parameter int MEM_DEPTH = 64,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_imem_we,
  input  logic          ld_dmem_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  output logic [31:0]   pc_out,
  input  logic [4:0]    peek_reg,
  output logic [31:0]   peek_reg_data,
  input  logic [AW-1:0] peek_addr,
  output logic [31:0]   peek_mem_data
);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_SWAI  = 6'h3B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
  localparam logic [5:0] FN_JR  = 6'h08;

  localparam logic [2:0] AC_ADD = 3'd0;
  localparam logic [2:0] AC_SUB = 3'd1;
  localparam logic [2:0] AC_AND = 3'd2;
  localparam logic [2:0] AC_OR  = 3'd3;
  localparam logic [2:0] AC_SLT = 3'd4;

  logic [31:0] pc;
  logic [31:0] imem [MEM_DEPTH];
  logic [31:0] dmem [MEM_DEPTH];
  logic [31:0] rf   [32];

  logic [31:0] instr;
  logic [5:0]  opc, fn;
  logic [4:0]  rs_f, rt_f, rd_f;
  logic [15:0] imm;
  logic [31:0] sext;
  logic        i_in_range;

  assign i_in_range = (pc[31:AW+2] == '0);
  assign instr = i_in_range ? imem[pc[AW+1:2]] : '0;
  assign opc  = instr[31:26];
  assign rs_f = instr[25:21];
  assign rt_f = instr[20:16];
  assign rd_f = instr[15:11];
  assign fn   = instr[5:0];
  assign imm  = instr[15:0];
  assign sext = {{16{imm[15]}}, imm};

  logic       reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write;
  logic       branch, jump_reg, do_lui, do_swai;
  logic [1:0] alu_op;

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_write  = 1'b0;
    mem_read   = 1'b0;
    mem_write  = 1'b0;
    branch     = 1'b0;
    alu_op     = 2'b00;
    jump_reg   = 1'b0;
    do_lui     = 1'b0;
    do_swai    = 1'b0;
    case (opc)
      OP_RTYPE: begin
        if (fn == FN_JR) begin
          jump_reg = 1'b1;
        end else begin
          reg_dst   = 1'b1;
          reg_write = 1'b1;
          alu_op    = 2'b10;
        end
      end
      OP_LW: begin
        alu_src    = 1'b1;
        mem_to_reg = 1'b1;
        reg_write  = 1'b1;
        mem_read   = 1'b1;
      end
      OP_SW: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = 2'b01;
      end
      OP_LUI: begin
        reg_write = 1'b1;
        do_lui    = 1'b1;
      end
      OP_SWAI: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
        reg_write = 1'b1;
        do_swai   = 1'b1;
      end
      default: ;
    endcase
  end

  logic [2:0] alu_ctl;

  always_comb begin
    case (alu_op)
      2'b00:   alu_ctl = AC_ADD;
      2'b01:   alu_ctl = AC_SUB;
      default: begin
        case (fn)
          FN_SUB:  alu_ctl = AC_SUB;
          FN_AND:  alu_ctl = AC_AND;
          FN_OR:   alu_ctl = AC_OR;
          FN_SLT:  alu_ctl = AC_SLT;
          FN_ADD:  alu_ctl = AC_ADD;
          default: alu_ctl = AC_ADD;
        endcase
      end
    endcase
  end

  logic [31:0] rs_val, rt_val, alu_b, alu_res;
  logic        zero;

  assign rs_val = (rs_f == 5'd0) ? '0 : rf[rs_f];
  assign rt_val = (rt_f == 5'd0) ? '0 : rf[rt_f];
  assign alu_b  = alu_src ? sext : rt_val;

  always_comb begin
    case (alu_ctl)
      AC_SUB:  alu_res = rs_val - alu_b;
      AC_AND:  alu_res = rs_val & alu_b;
      AC_OR:   alu_res = rs_val | alu_b;
      AC_SLT:  alu_res = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_res = rs_val + alu_b;
    endcase
  end

  assign zero = (alu_res == '0);

  logic        d_in_range;
  logic [31:0] dmem_rd;

  assign d_in_range = (alu_res[31:AW+2] == '0);
  assign dmem_rd = (mem_read && d_in_range) ? dmem[alu_res[AW+1:2]] : '0;

  logic [31:0] pc4, br_target, pc_br, pc_next;

  assign pc4       = pc + 32'd4;
  assign br_target = pc4 + {sext[29:0], 2'b00};
  assign pc_br     = (branch && zero) ? br_target : pc4;
  assign pc_next   = jump_reg ? rs_val : pc_br;

  logic [31:0] rs_inc, wb;
  logic [4:0]  wreg;

  assign rs_inc = rs_val + 32'd4;
  assign wreg   = do_swai ? rs_f : (reg_dst ? rd_f : rt_f);
  assign wb     = do_lui ? {imm, 16'd0} :
                  do_swai ? rs_inc :
                  mem_to_reg ? dmem_rd : alu_res;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (reg_write && wreg != 5'd0) begin
      rf[wreg] <= wb;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_dmem_we) dmem[ld_addr] <= ld_data;
    else if (!rst && mem_write && d_in_range) dmem[alu_res[AW+1:2]] <= rt_val;
  end

  assign pc_out        = pc;
  assign peek_reg_data = (peek_reg == 5'd0) ? '0 : rf[peek_reg];
  assign peek_mem_data = dmem[peek_addr];

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (branch && zero) |=> (pc == $past(pc) + 32'd4 + {$past(sext[29:0]), 2'b00})); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!jump_reg && !(branch && zero)) |=> (pc == $past(pc) + 32'd4)); // R10

  AST_JR_TARGET: assert property (@(posedge clk) disable iff (rst)
    jump_reg |=> (pc == $past(rs_val))); // R6

  AST_JR_QUIET: assert property (@(posedge clk) disable iff (rst)
    jump_reg |-> (!reg_write && !mem_write)); // R6

  AST_SWAI_BASE: assert property (@(posedge clk) disable iff (rst)
    (do_swai && rs_f != 5'd0) |=> (rf[$past(rs_f)] == $past(rs_val) + 32'd4)); // R8

  AST_LUI_NOMEM: assert property (@(posedge clk) disable iff (rst)
    do_lui |-> !mem_write); // R7

endmodule

// File: tb/sim_sc_cpu.sv
module sim_sc_cpu;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] HALT = 32'h1000FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   pc_out;
  logic [4:0]    peek_reg = '0;
  logic [31:0]   peek_reg_data;
  logic [AW-1:0] peek_addr = '0;
  logic [31:0]   peek_mem_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] prog [DEPTH];
  logic [31:0] dm   [DEPTH];

  always #10 clk = ~clk;

  sc_cpu #(.MEM_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_out(pc_out),
    .peek_reg(peek_reg), .peek_reg_data(peek_reg_data),
    .peek_addr(peek_addr), .peek_mem_data(peek_mem_data)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [4:0] r, input logic [31:0] exp);
    peek_reg = r;
    #1;
    check(tag, peek_reg_data, exp);
  endtask

  task automatic chk_mem(input string tag, input int w, input logic [31:0] exp);
    peek_addr = AW'(w);
    #1;
    check(tag, peek_mem_data, exp);
  endtask

  task automatic clear_images();
    for (int i = 0; i < DEPTH; i++) begin
      prog[i] = HALT;
      dm[i] = '0;
    end
  endtask

  task automatic load_and_start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      ld_imem_we = 1'b1; ld_addr = AW'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_imem_we = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      ld_dmem_we = 1'b1; ld_addr = AW'(i); ld_data = dm[i];
      @(negedge clk);
    end
    ld_dmem_we = 1'b0;
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 pc cleared", pc_out, 32'd0);
    chk_reg("R1 reg1 cleared", 5'd1, 32'd0);
    chk_reg("R1 reg8 cleared", 5'd8, 32'd0);
  endtask

  task automatic t_alu();
    clear_images();
    dm[0] = 32'd7; dm[1] = 32'hFFFFFFFD;
    prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
    prog[2] = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
    prog[3] = enc_r(5'd1, 5'd2, 5'd4, 6'h22);
    prog[4] = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
    prog[5] = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
    prog[6] = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);
    prog[7] = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);
    load_and_start();
    run(8);
    chk_reg("R3 lw reg1", 5'd1, 32'd7);
    chk_reg("R3 lw reg2", 5'd2, 32'hFFFFFFFD);
    chk_reg("R2 add", 5'd3, 32'd4);
    chk_reg("R2 sub", 5'd4, 32'd10);
    chk_reg("R2 and", 5'd5, 32'd5);
    chk_reg("R2 or", 5'd6, 32'hFFFFFFFF);
    chk_reg("R2 slt true", 5'd7, 32'd1);
    chk_reg("R2 slt false", 5'd8, 32'd0);
    check("R10 pc after 8 steps", pc_out, 32'd32);
  endtask

  task automatic t_store();
    clear_images();
    dm[0] = 32'd16;
    prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = enc_i(6'h2B, 5'd1, 5'd1, 16'hFFFC);
    load_and_start();
    run(2);
    chk_mem("R4 sw negative offset", 3, 32'd16);
    chk_reg("R4 sw no rd write", 5'd31, 32'd0);
    chk_reg("R4 sw rt kept", 5'd1, 32'd16);
    check("R10 pc after sw", pc_out, 32'd8);
  endtask

  task automatic t_branch();
    clear_images();
    dm[0] = 32'd5;
    prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd0);
    prog[2] = enc_i(6'h04, 5'd1, 5'd2, 16'd2);
    prog[3] = enc_i(6'h0F, 5'd0, 5'd3, 16'd1);
    prog[4] = enc_i(6'h0F, 5'd0, 5'd4, 16'd2);
    prog[5] = enc_i(6'h04, 5'd1, 5'd0, 16'd1);
    prog[6] = enc_i(6'h0F, 5'd0, 5'd5, 16'd3);
    load_and_start();
    run(3);
    check("R5 beq taken target", pc_out, 32'd20);
    run(1);
    check("R5 beq not taken", pc_out, 32'd24);
    run(1);
    check("R10 pc after lui", pc_out, 32'd28);
    chk_reg("R5 skipped slot 3", 5'd3, 32'd0);
    chk_reg("R5 skipped slot 4", 5'd4, 32'd0);
    chk_reg("R7 lui after fallthrough", 5'd5, 32'h00030000);
    run(3);
    check("R5 backward self branch", pc_out, 32'd28);
  endtask

  task automatic t_jr();
    clear_images();
    dm[0] = 32'd24;
    prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = enc_r(5'd1, 5'd0, 5'd5, 6'h08);
    prog[2] = enc_i(6'h0F, 5'd0, 5'd2, 16'd7);
    prog[6] = enc_i(6'h0F, 5'd0, 5'd3, 16'hABCD);
    load_and_start();
    run(2);
    check("R6 jr target", pc_out, 32'd24);
    chk_reg("R6 jr no rd write", 5'd5, 32'd0);
    run(1);
    check("R10 pc after jr landing", pc_out, 32'd28);
    chk_reg("R6 skipped slot", 5'd2, 32'd0);
    chk_reg("R7 lui at target", 5'd3, 32'hABCD0000);
  endtask

  task automatic t_lui();
    clear_images();
    dm[0] = 32'hCAFE0001;
    dm[9] = 32'h12345678;
    prog[0] = enc_i(6'h0F, 5'd0, 5'd9, 16'h8001);
    prog[1] = enc_i(6'h0F, 5'd0, 5'd0, 16'h1234);
    prog[2] = enc_r(5'd0, 5'd9, 5'd10, 6'h25);
    load_and_start();
    run(3);
    chk_reg("R7 lui value", 5'd9, 32'h80010000);
    chk_reg("R9 lui to r0 ignored", 5'd0, 32'd0);
    chk_reg("R9 r0 reads zero", 5'd10, 32'h80010000);
    chk_mem("R7 lui no mem write w0", 0, 32'hCAFE0001);
    chk_mem("R7 lui no mem write w9", 9, 32'h12345678);
  endtask

  task automatic t_swai();
    clear_images();
    dm[0] = 32'd8; dm[1] = 32'h55;
    prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
    prog[2] = enc_i(6'h3B, 5'd1, 5'd2, 16'd4);
    prog[3] = enc_i(6'h3B, 5'd1, 5'd1, 16'd4);
    prog[4] = enc_i(6'h3B, 5'd0, 5'd2, 16'd20);
    load_and_start();
    run(3);
    chk_mem("R8 swai store", 3, 32'h55);
    chk_reg("R8 swai base +4", 5'd1, 32'd12);
    run(2);
    chk_mem("R8 swai stores original base", 4, 32'd12);
    chk_reg("R8 swai base again", 5'd1, 32'd16);
    chk_mem("R8 swai rs zero store", 5, 32'h55);
    chk_reg("R9 swai on r0", 5'd0, 32'd0);
    check("R10 pc after swai", pc_out, 32'd20);
  endtask

  task automatic t_r0();
    clear_images();
    dm[0] = 32'd21;
    prog[0] = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
    prog[2] = enc_r(5'd0, 5'd1, 5'd11, 6'h20);
    load_and_start();
    run(3);
    chk_reg("R9 add to r0 ignored", 5'd0, 32'd0);
    chk_reg("R9 r0 operand", 5'd11, 32'd21);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_alu();
    t_store();
    t_branch();
    t_jr();
    t_lui();
    t_swai();
    t_r0();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule